// File: doc/BRIEF.md
# Coprocessor Bus-Cycle Ready Generator

This block sits on the slave side of a numeric coprocessor attached to a host CPU's local bus. At the first period of each bus cycle (marked by a cycle-start qualifier) it decides whether the cycle targets the coprocessor. A cycle is selected when the chip-enable, an active-low I/O-cycle select and an active-high address select are all valid together. For a selected cycle it records whether the cycle is a read or a write and whether it carries a command or data. It then counts clocks and drives an active-low ready output at the point where the cycle may complete.

The block also watches the shared bus-ready input, so it tracks every cycle, selected or not, for as long as the host stretches it. During block-transfer instructions (environment load or state restore) it paces an operand-request line in bursts of two words. It holds the request low after each burst until the FIFO reports room for two more. It also lengthens the writes the host needs time to react to. Every output that goes to a pad comes with an enable flag, and the chip-enable gates all of those enables.

Top module: `cprdy_top`

## Requirements
- R1: A cycle is selected only when `chip_en`=1, `sel_io_n`=0 and `sel_addr`=1 in the clock where `cyc_start`=1. An unselected cycle never drives `rdy_n_o` low, and it produces no transfer strobe.
- R2: The clock where `cyc_start`=1 counts as clock 1. A selected ordinary write drives `rdy_n_o` low from clock 2.
- R3: A selected read drives `rdy_n_o` low from clock 3 and keeps it high in clock 2.
- R4: `rdy_n_o` is low only inside a selected cycle. Once low, it stays low until the clock in which `bus_rdy_n` is sampled low.
- R5: A cycle, selected or not, stays open until `bus_rdy_n` is low at a clock edge. It may be stretched by any number of wait clocks.
- R6: In the final clock of a selected write, `op_wr_stb`=1 when `cmd_n`=0 (opcode) and `dat_wr_stb`=1 when `cmd_n`=1 (operand data).
- R7: During a selected read, `rd_ctl_sel`=1 when `cmd_n`=0 (control/status register) and 0 when `cmd_n`=1 (data register).
- R8: While `chip_en`=0, the enables `rdy_oe`, `opreq_oe`, `busy_oe` and `err_oe` are all 0. While `chip_en`=1 they are all 1.
- R9: `data_oe`=1 only while `chip_en`=1 and a selected read cycle is open.
- R10: With `blk_mode`=1, `opreq_o`=1 until two operand-data writes have completed. It is then 0 from the next clock until `fifo_room2`=1 is sampled, and goes back to 1 in the clock after that.
- R11: With `blk_mode`=1, the first operand-data write after `blk_mode` rises and the second write of each two-word burst drive `rdy_n_o` low from clock 3. All other writes still use clock 2.
- R12: After reset, `rdy_n_o`=1, `opreq_o`=0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | High in the first period of a host bus cycle |
| chip_en | input | 1 | Chip enable, sampled with the selects and also gating all pad enables |
| sel_io_n | input | 1 | Active-low I/O-cycle select |
| sel_addr | input | 1 | Active-high address-bit select |
| wr_cycle | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_n | input | 1 | Active-low command/control qualifier |
| bus_rdy_n | input | 1 | Shared active-low bus ready |
| blk_mode | input | 1 | Block-transfer instruction in progress |
| fifo_room2 | input | 1 | FIFO can take two more words |
| core_busy | input | 1 | Busy flag from the arithmetic core |
| core_err | input | 1 | Error flag from the arithmetic core |
| rdy_n_o | output | 1 | Active-low ready value |
| rdy_oe | output | 1 | Ready pad enable |
| opreq_o | output | 1 | Operand request value |
| opreq_oe | output | 1 | Operand request pad enable |
| busy_n_o | output | 1 | Active-low busy value |
| busy_oe | output | 1 | Busy pad enable |
| err_n_o | output | 1 | Active-low error value |
| err_oe | output | 1 | Error pad enable |
| data_oe | output | 1 | Data-bus output enable |
| op_wr_stb | output | 1 | Opcode write completes this clock |
| dat_wr_stb | output | 1 | Operand data write completes this clock |
| rd_ctl_sel | output | 1 | Selected read addresses control/status register |

## Verification
The assertions assume the host obeys the bus protocol. Under that protocol `cyc_start` is raised only when no cycle is open, and the selects, `chip_en`, `cmd_n` and `wr_cycle` stay steady for the whole cycle. They also assume `bus_rdy_n` is driven low only at or after the clock where this block's own ready appears for selected cycles. The driver task keeps to these rules. It opens one cycle at a time and holds every qualifier until the cycle ends. It returns `bus_rdy_n` low only after the ready it observes, plus a chosen number of wait clocks, or after a fixed delay for unselected cycles.

// File: rtl/cprdy_pkg.sv
// Package: shared types and helpers for the coprocessor ready generator.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package cprdy_pkg;

    // Snapshot of the qualifiers captured in the first period of a cycle.
    typedef struct packed {
        logic sel;  // cycle targets this block
        logic wr;   // 1 = write
        logic cmd;  // command qualifier active (cmd_n was low)
    } cyc_info_t;

    // Largest of three clock counts, used to size the cycle counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cprdy_cycle_trk.sv
// Module: cprdy_cycle_trk
// Opens a cycle record on cyc_start, qualifies the selects, picks the cycle
// length and counts clocks until the shared bus ready is sampled active.
// Assumes cyc_start is only raised while no cycle is open.
module cprdy_cycle_trk
    import cprdy_pkg::*;
#(
    parameter int WR_CLKS   = 2,
    parameter int RD_CLKS   = 3,
    parameter int LONG_CLKS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cyc_start,
    input  logic      chip_en,
    input  logic      sel_io_n,
    input  logic      sel_addr,
    input  logic      wr_cycle,
    input  logic      cmd_n,
    input  logic      bus_rdy_n,
    input  logic      long_wr,
    output logic      in_cyc,
    output cyc_info_t info,
    output logic      rdy_act,
    output logic      cyc_end
);
    localparam int CNT_MAX = max3(WR_CLKS, RD_CLKS, LONG_CLKS);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WR_TGT   = CNT_W'(WR_CLKS - 1);
    localparam logic [CNT_W-1:0] RD_TGT   = CNT_W'(RD_CLKS - 1);
    localparam logic [CNT_W-1:0] LONG_TGT = CNT_W'(LONG_CLKS - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] tgt_d;
    logic             start_ok;

    // Accept a new cycle only when none is open.
    assign start_ok = cyc_start && !in_cyc;

    // Select the clock index at which ready is due for the new cycle.
    always_comb begin
        if (!wr_cycle)              tgt_d = RD_TGT;
        else if (long_wr && cmd_n)  tgt_d = LONG_TGT;
        else                        tgt_d = WR_TGT;
    end

    // Cycle record: open, count and close on sampled bus ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cyc <= 1'b0;
            info   <= '0;
            cnt_q  <= '0;
            tgt_q  <= '0;
        end else if (start_ok) begin
            in_cyc   <= 1'b1;
            info.sel <= chip_en && !sel_io_n && sel_addr;
            info.wr  <= wr_cycle;
            info.cmd <= !cmd_n;
            cnt_q    <= CNT_W'(1);
            tgt_q    <= tgt_d;
        end else if (in_cyc) begin
            if (!bus_rdy_n) begin
                in_cyc <= 1'b0;
                info   <= '0;
            end else if (cnt_q != CNT_TOP) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign rdy_act = in_cyc && info.sel && (cnt_q >= tgt_q);
    assign cyc_end = in_cyc && !bus_rdy_n;

    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cyc && bus_rdy_n) |=> in_cyc);  // R5

    AST_CLOSE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cyc && !bus_rdy_n && !cyc_start) |=> !in_cyc);  // R5

endmodule

// File: rtl/cprdy_burst_ctl.sv
// Module: cprdy_burst_ctl
// Paces the operand request in bursts of BURST_WORDS operand writes and
// flags which block-transfer writes need the long ready timing.
// Assumes fifo_room2 is only meaningful while a burst is held off.
module cprdy_burst_ctl #(
    parameter int BURST_WORDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_mode,
    input  logic fifo_room2,
    input  logic dat_wr_done,
    output logic opreq,
    output logic long_wr
);
    localparam int BW_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [BW_W-1:0] LAST_IDX = BW_W'(BURST_WORDS - 1);

    logic [BW_W-1:0] widx_q;
    logic            first_q;
    logic            hold_q;

    // Burst bookkeeping: word index, first-word flag and hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n || !blk_mode) begin
            widx_q  <= '0;
            first_q <= 1'b1;
            hold_q  <= 1'b0;
        end else if (dat_wr_done) begin
            first_q <= 1'b0;
            if (widx_q == LAST_IDX) begin
                widx_q <= '0;
                hold_q <= 1'b1;
            end else begin
                widx_q <= widx_q + BW_W'(1);
            end
        end else if (hold_q && fifo_room2) begin
            hold_q <= 1'b0;
        end
    end

    assign opreq   = blk_mode && !hold_q;
    assign long_wr = blk_mode && (first_q || (widx_q == LAST_IDX));

    AST_BURST_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_done && blk_mode && widx_q == LAST_IDX) |=> !opreq);  // R10

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mode |-> !opreq);  // R10

endmodule

// File: rtl/cprdy_out_gate.sv
// Module: cprdy_out_gate
// Forms the pad values and their enables; chip_en gates every enable.
// Assumes the pad drivers themselves live outside this block.
module cprdy_out_gate (
    input  logic chip_en,
    input  logic rdy_act,
    input  logic opreq,
    input  logic core_busy,
    input  logic core_err,
    input  logic rd_open,
    output logic rdy_n_o,
    output logic rdy_oe,
    output logic opreq_o,
    output logic opreq_oe,
    output logic busy_n_o,
    output logic busy_oe,
    output logic err_n_o,
    output logic err_oe,
    output logic data_oe
);
    // Values and chip-enable-gated enables.
    always_comb begin
        rdy_n_o  = !rdy_act;
        opreq_o  = opreq;
        busy_n_o = !core_busy;
        err_n_o  = !core_err;
        rdy_oe   = chip_en;
        opreq_oe = chip_en;
        busy_oe  = chip_en;
        err_oe   = chip_en;
        data_oe  = chip_en && rd_open;
    end

endmodule

// File: rtl/cprdy_top.sv
// Module: cprdy_top
// Slave-side bus-cycle tracker and ready generator for a coprocessor.
// Assumes a single clock, with cyc_start marking the first period of each
// host cycle and all qualifiers held steady until the cycle closes.
module cprdy_top
    import cprdy_pkg::*;
#(
    parameter int WR_CLKS     = 2,
    parameter int RD_CLKS     = 3,
    parameter int LONG_CLKS   = 3,
    parameter int BURST_WORDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic chip_en,
    input  logic sel_io_n,
    input  logic sel_addr,
    input  logic wr_cycle,
    input  logic cmd_n,
    input  logic bus_rdy_n,
    input  logic blk_mode,
    input  logic fifo_room2,
    input  logic core_busy,
    input  logic core_err,
    output logic rdy_n_o,
    output logic rdy_oe,
    output logic opreq_o,
    output logic opreq_oe,
    output logic busy_n_o,
    output logic busy_oe,
    output logic err_n_o,
    output logic err_oe,
    output logic data_oe,
    output logic op_wr_stb,
    output logic dat_wr_stb,
    output logic rd_ctl_sel
);
    cyc_info_t info;
    logic      in_cyc;
    logic      rdy_act;
    logic      cyc_end;
    logic      long_wr;
    logic      opreq;
    logic      sel_wr_end;
    logic      rd_open;

    cprdy_cycle_trk #(
        .WR_CLKS   (WR_CLKS),
        .RD_CLKS   (RD_CLKS),
        .LONG_CLKS (LONG_CLKS)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .chip_en   (chip_en),
        .sel_io_n  (sel_io_n),
        .sel_addr  (sel_addr),
        .wr_cycle  (wr_cycle),
        .cmd_n     (cmd_n),
        .bus_rdy_n (bus_rdy_n),
        .long_wr   (long_wr),
        .in_cyc    (in_cyc),
        .info      (info),
        .rdy_act   (rdy_act),
        .cyc_end   (cyc_end)
    );

    // Transfer classification for the closing clock and for open reads.
    assign sel_wr_end = cyc_end && info.sel && info.wr;
    assign op_wr_stb  = sel_wr_end && info.cmd;
    assign dat_wr_stb = sel_wr_end && !info.cmd;
    assign rd_open    = in_cyc && info.sel && !info.wr;
    assign rd_ctl_sel = rd_open && info.cmd;

    cprdy_burst_ctl #(
        .BURST_WORDS (BURST_WORDS)
    ) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_mode    (blk_mode),
        .fifo_room2  (fifo_room2),
        .dat_wr_done (dat_wr_stb),
        .opreq       (opreq),
        .long_wr     (long_wr)
    );

    cprdy_out_gate u_gate (
        .chip_en   (chip_en),
        .rdy_act   (rdy_act),
        .opreq     (opreq),
        .core_busy (core_busy),
        .core_err  (core_err),
        .rd_open   (rd_open),
        .rdy_n_o   (rdy_n_o),
        .rdy_oe    (rdy_oe),
        .opreq_o   (opreq_o),
        .opreq_oe  (opreq_oe),
        .busy_n_o  (busy_n_o),
        .busy_oe   (busy_oe),
        .err_n_o   (err_n_o),
        .err_oe    (err_oe),
        .data_oe   (data_oe)
    );

    AST_RDY_SELECTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n_o |-> (in_cyc && info.sel));  // R4

    AST_SHORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !in_cyc && chip_en && !sel_io_n && sel_addr && wr_cycle
         && !(long_wr && cmd_n)) |=> !rdy_n_o);  // R2

    AST_READ_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !in_cyc && chip_en && !sel_io_n && sel_addr && !wr_cycle)
         |=> rdy_n_o);  // R3

    AST_LONG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !in_cyc && wr_cycle && cmd_n && long_wr) |=> rdy_n_o);  // R11

    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !in_cyc && !(chip_en && !sel_io_n && sel_addr))
         |=> (rdy_n_o && !op_wr_stb && !dat_wr_stb));  // R1

    AST_DATA_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (chip_en && in_cyc && info.sel && !info.wr));  // R9

endmodule

// File: tb/tb_cprdy_top.sv
module tb_cprdy_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 0, chip_en = 1, sel_io_n = 1, sel_addr = 0;
    logic wr_cycle = 0, cmd_n = 1, bus_rdy_n = 1;
    logic blk_mode = 0, fifo_room2 = 0, core_busy = 0, core_err = 0;
    logic rdy_n_o, rdy_oe, opreq_o, opreq_oe, busy_n_o, busy_oe;
    logic err_n_o, err_oe, data_oe, op_wr_stb, dat_wr_stb, rd_ctl_sel;

    int total = 0;
    int bad = 0;

    typedef struct {
        string tag;
        int    rdy_idx;
        bit    op;
        bit    dat;
        bit    rdctl;
        bit    doe;
    } exp_t;
    exp_t sb[$];

    bit m_first = 1;
    int m_widx = 0;

    always #2 clk = ~clk;  // 250 MHz

    cprdy_top dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .chip_en(chip_en),
        .sel_io_n(sel_io_n), .sel_addr(sel_addr), .wr_cycle(wr_cycle),
        .cmd_n(cmd_n), .bus_rdy_n(bus_rdy_n), .blk_mode(blk_mode),
        .fifo_room2(fifo_room2), .core_busy(core_busy), .core_err(core_err),
        .rdy_n_o(rdy_n_o), .rdy_oe(rdy_oe), .opreq_o(opreq_o),
        .opreq_oe(opreq_oe), .busy_n_o(busy_n_o), .busy_oe(busy_oe),
        .err_n_o(err_n_o), .err_oe(err_oe), .data_oe(data_oe),
        .op_wr_stb(op_wr_stb), .dat_wr_stb(dat_wr_stb), .rd_ctl_sel(rd_ctl_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Driver: run one bus cycle and push its expected outcome.
    task automatic bus_cycle(input string tag, input bit en, input bit io_n,
                             input bit addr, input bit wr, input bit cn,
                             input int waits);
        exp_t e;
        bit sel;
        bit done;
        int w;
        int idx;
        sel = en && !io_n && addr;
        e.tag = tag;
        e.rdy_idx = 0;
        if (sel) begin
            if (!wr) e.rdy_idx = 3;
            else if (blk_mode && cn) e.rdy_idx = (m_first || m_widx == 1) ? 3 : 2;
            else e.rdy_idx = 2;
        end
        if (sel && wr && cn && blk_mode) begin
            m_first = 0;
            m_widx = (m_widx == 1) ? 0 : 1;
        end
        e.op = sel && wr && !cn;
        e.dat = sel && wr && cn;
        e.rdctl = sel && !wr && !cn;
        e.doe = sel && !wr && en;
        sb.push_back(e);
        @(posedge clk); #1;
        chip_en = en; sel_io_n = io_n; sel_addr = addr;
        wr_cycle = wr; cmd_n = cn; cyc_start = 1; bus_rdy_n = 1;
        @(posedge clk); #1;
        cyc_start = 0;
        idx = 2; w = 0; done = 0;
        while (!done) begin
            if (sel) begin
                if (!rdy_n_o) begin
                    if (w == waits) done = 1;
                    else w++;
                end
            end else if (idx >= 2 + waits) begin
                done = 1;
            end
            if (done) begin
                bus_rdy_n = 0;
                @(posedge clk); #1;
                bus_rdy_n = 1;
            end else begin
                @(posedge clk); #1;
                idx++;
            end
        end
    endtask

    // Monitor: follow each cycle at the falling edge and compare with the queue.
    initial begin
        bit active;
        int idx;
        int first;
        bit held_bad;
        bit rc;
        bit de;
        exp_t e;
        active = 0; idx = 0; first = 0; held_bad = 0; rc = 0; de = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cyc_start) begin
                    active = 1; idx = 1; first = 0; held_bad = 0; rc = 0; de = 0;
                end else if (active) begin
                    idx++;
                end
                if (active) begin
                    if (!rdy_n_o && first == 0) first = idx;
                    if (rdy_n_o && first != 0) held_bad = 1;
                    if (idx == 2) begin rc = rd_ctl_sel; de = data_oe; end
                    if (!bus_rdy_n) begin
                        e = sb.pop_front();
                        chk({e.tag, " R2/R3/R11 ready clock"}, first, e.rdy_idx);
                        chk({e.tag, " R4 ready held"}, int'(held_bad), 0);
                        chk({e.tag, " R6 opcode strobe"}, int'(op_wr_stb), int'(e.op));
                        chk({e.tag, " R6 data strobe"}, int'(dat_wr_stb), int'(e.dat));
                        chk({e.tag, " R7 ctl select"}, int'(rc), int'(e.rdctl));
                        chk({e.tag, " R9 data oe"}, int'(de), int'(e.doe));
                        active = 0;
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R12 ready idle", int'(rdy_n_o), 1);
        chk("R12 opreq idle", int'(opreq_o), 0);
        chk("R12 strobes idle", int'(op_wr_stb | dat_wr_stb), 0);

        bus_cycle("R2 opcode write", 1, 0, 1, 1, 0, 0);
        bus_cycle("R6 data write", 1, 0, 1, 1, 1, 0);
        bus_cycle("R3 status read", 1, 0, 1, 0, 0, 0);
        bus_cycle("R7 data read", 1, 0, 1, 0, 1, 0);
        bus_cycle("R1 no io select", 1, 1, 1, 1, 0, 0);
        bus_cycle("R1 no addr select", 1, 0, 0, 0, 0, 1);
        bus_cycle("R1 chip disabled", 0, 0, 1, 1, 1, 0);
        bus_cycle("R5 stretched write", 1, 0, 1, 1, 1, 3);
        bus_cycle("R5 stretched read", 1, 0, 1, 0, 0, 2);
        bus_cycle("R5 stretched other", 1, 1, 0, 1, 1, 4);

        @(posedge clk); #1 chip_en = 0; core_busy = 1;
        @(negedge clk);
        chk("R8 oe off", int'(rdy_oe | opreq_oe | busy_oe | err_oe), 0);
        chk("R9 data oe off", int'(data_oe), 0);
        @(posedge clk); #1 chip_en = 1;
        @(negedge clk);
        chk("R8 oe on", int'(rdy_oe & opreq_oe & busy_oe & err_oe), 1);
        chk("R8 busy value", int'(busy_n_o), 0);
        core_busy = 0;

        @(posedge clk); #1 blk_mode = 1; fifo_room2 = 0; m_first = 1; m_widx = 0;
        @(negedge clk);
        chk("R10 request on entry", int'(opreq_o), 1);
        bus_cycle("R11 first word", 1, 0, 1, 1, 1, 0);
        @(negedge clk);
        chk("R10 request mid burst", int'(opreq_o), 1);
        bus_cycle("R11 burst end", 1, 0, 1, 1, 1, 0);
        @(negedge clk);
        chk("R10 request paused", int'(opreq_o), 0);
        bus_cycle("R11 opcode short", 1, 0, 1, 1, 0, 0);
        @(negedge clk);
        chk("R10 still paused", int'(opreq_o), 0);
        @(posedge clk); #1 fifo_room2 = 1;
        @(negedge clk);
        chk("R10 not yet resumed", int'(opreq_o), 0);
        @(posedge clk); #1 fifo_room2 = 0;
        @(negedge clk);
        chk("R10 resumed", int'(opreq_o), 1);
        bus_cycle("R11 mid burst short", 1, 0, 1, 1, 1, 0);
        bus_cycle("R11 second burst end", 1, 0, 1, 1, 1, 1);
        @(negedge clk);
        chk("R10 paused again", int'(opreq_o), 0);
        @(posedge clk); #1 blk_mode = 0;
        @(negedge clk);
        chk("R10 off outside block", int'(opreq_o), 0);
        bus_cycle("R2 write after block", 1, 0, 1, 1, 1, 0);

        repeat (3) @(posedge clk);
        chk("R5 scoreboard drained", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule